// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is a packed-SIMD integer execution unit. Each operation carries its own 12-bit control word, which selects the total vector width, the lane element width, the overflow behaviour and the operator. No vector configuration state is kept between operations, so one register can be read as sixteen bytes on one cycle and as two 64-bit words on the next. It takes two source vectors and an accumulator vector. A per-lane enable mask decides which lanes are written, and any lane that is not written passes the first source through.

The unit offers add, subtract, low-half multiply, multiply-accumulate and high-half multiply. Results can wrap, saturate as signed values or saturate as unsigned values. The result is registered, together with a valid strobe and a flag that marks control words the unit cannot execute (floating-point category, reserved width code, unknown operator). An illegal operation yields an all-zero result.

Top module: `simd_int_alu`

## Requirements
- R1: `res_valid` equals the value `in_valid` had one clock earlier. Reset clears `res_valid`, `res_illegal` and `result`.
- R2: Control bits [1:0] select the vector width: 0 means 64 bits and 1 means 128 bits. Codes 2 and 3 raise `res_illegal` and give a zero result.
- R3: Control bits [3:2] select the lane width: 0, 1, 2 and 3 mean 8, 16, 32 and 64 bits. Lane j occupies result bits [j*W +: W].
- R4: Control bits [5:4] select the category: 0 wrap, 2 signed saturate, 3 unsigned saturate. Code 1 (floating point) raises `res_illegal` and gives a zero result.
- R5: Control bits [11:6] select the operator: 0 add, 1 sub, 2 mul (low half), 3 mac, 4 mulhi. Any other code raises `res_illegal` and gives a zero result.
- R6: In the wrap category, add, sub, mul and mac return the low W bits of the exact result.
- R7: In the signed saturating category, add, sub, mul and mac clamp the exact result to the range from -2^(W-1) to 2^(W-1)-1.
- R8: In the unsigned saturating category, add, sub, mul and mac clamp the exact result to the range from 0 to 2^W-1.
- R9: mulhi returns bits [2W-1:W] of the full product. The operands are taken as signed in the signed saturating category and as unsigned in the other categories. mulhi never saturates.
- R10: mac computes `src_acc` lane + `src_a` lane × `src_b` lane exactly and then applies the category's wrap or clamp rule.
- R11: `lane_mask` bit j enables lane j. A lane whose bit is 0 returns its `src_a` bits unchanged. Mask bits at or above the active lane count are ignored.
- R12: With the 64-bit width, result bits [127:64] are zero. Mask bits for lanes that lie above bit 63 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation strobe |
| ctrl | input | 12 | Control word: width, lane size, category, operator |
| src_a | input | 128 | First source vector, also the pass-through value for disabled lanes |
| src_b | input | 128 | Second source vector |
| src_acc | input | 128 | Accumulator vector for mac |
| lane_mask | input | 16 | Per-lane enable, bit j for lane j |
| res_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| res_illegal | output | 1 | Control word was not executable |
| result | output | 128 | Registered result vector |

## Verification
The vectors aim at the points where the lane arithmetic turns over. They cover signed overflow just past the top and bottom of the range, unsigned underflow and overflow, a product wider than its lane, and an accumulate that carries past the signed maximum. A unit that clamped with the wrong limits, or that truncated before clamping, would return wrapped values in these cases. mulhi is given operands whose upper product half differs between signed and unsigned readings, so treating the operands the wrong way shows up directly. Masks with holes, masks with stray high bits, and the 64-bit width check that disabled lanes keep the first source and that the upper half is cleared. A design that indexed the mask by byte rather than by lane, or that let upper lanes through in the narrow width, would corrupt those bytes. Reserved width, floating-point and unknown operator codes must return a zero result with the flag set.

// File: rtl/simd_pkg.sv
package simd_pkg;

   typedef enum logic [1:0] {
      VW_NARROW = 2'd0,
      VW_WIDE   = 2'd1,
      VW_RSV2   = 2'd2,
      VW_RSV3   = 2'd3
   } vw_e;

   typedef enum logic [1:0] {
      CAT_WRAP = 2'd0,
      CAT_FLT  = 2'd1,
      CAT_SSAT = 2'd2,
      CAT_USAT = 2'd3
   } cat_e;

   typedef enum logic [5:0] {
      OP_ADD  = 6'd0,
      OP_SUB  = 6'd1,
      OP_MUL  = 6'd2,
      OP_MAC  = 6'd3,
      OP_MULH = 6'd4
   } op_e;

   localparam int CTRL_W     = 12;
   localparam int NUM_ELEM_W = 4;

   typedef struct packed {
      logic       narrow;
      logic [1:0] elem_sel;
      op_e        op;
      logic       signed_mode;
      logic       sat_en;
      logic       illegal;
   } dec_t;

endpackage

// File: rtl/simd_ctrl_decode.sv
module simd_ctrl_decode
   import simd_pkg::*;
(
   input  logic [CTRL_W-1:0] ctrl,
   output dec_t              dec
);

   vw_e  vw;
   cat_e cat;
   op_e  op;
   logic op_ok;

   always_comb begin
      vw  = vw_e'(ctrl[1:0]);
      cat = cat_e'(ctrl[5:4]);
      op  = op_e'(ctrl[11:6]);
      op_ok = (ctrl[11:6] <= 6'd4);

      dec.narrow      = (vw == VW_NARROW);
      dec.elem_sel    = ctrl[3:2];
      dec.op          = op;
      dec.signed_mode = (cat == CAT_SSAT);
      dec.sat_en      = (cat == CAT_SSAT) || (cat == CAT_USAT);
      dec.illegal     = (vw == VW_RSV2) || (vw == VW_RSV3) ||
                        (cat == CAT_FLT) || !op_ok;
   end

endmodule

// File: rtl/simd_lane_unit.sv
module simd_lane_unit
   import simd_pkg::*;
#(
   parameter int LANE_W = 8
)(
   input  logic [LANE_W-1:0] a,
   input  logic [LANE_W-1:0] b,
   input  logic [LANE_W-1:0] c,
   input  op_e               op,
   input  logic              signed_mode,
   input  logic              sat_en,
   output logic [LANE_W-1:0] y
);

   localparam int XW  = 2 * LANE_W + 2;
   localparam int EXT = LANE_W + 2;

   localparam logic [XW-1:0] SMAX = {{(LANE_W+3){1'b0}}, {(LANE_W-1){1'b1}}};
   localparam logic [XW-1:0] SMIN = {{(LANE_W+3){1'b1}}, {(LANE_W-1){1'b0}}};
   localparam logic [XW-1:0] UMAX = {{EXT{1'b0}}, {LANE_W{1'b1}}};

   if (LANE_W < 2) begin : g_bad_w
      $error("simd_lane_unit: LANE_W must be at least 2");
   end

   logic [XW-1:0] xa, xb, xc, prod, exact, hi_lim, lo_lim;

   always_comb begin
      xa = signed_mode ? {{EXT{a[LANE_W-1]}}, a} : {{EXT{1'b0}}, a};
      xb = signed_mode ? {{EXT{b[LANE_W-1]}}, b} : {{EXT{1'b0}}, b};
      xc = signed_mode ? {{EXT{c[LANE_W-1]}}, c} : {{EXT{1'b0}}, c};
      prod = xa * xb;

      unique case (op)
         OP_ADD:  exact = xa + xb;
         OP_SUB:  exact = xa - xb;
         OP_MUL:  exact = prod;
         OP_MAC:  exact = xc + prod;
         default: exact = '0;
      endcase

      hi_lim = signed_mode ? SMAX : UMAX;
      lo_lim = signed_mode ? SMIN : '0;

      if (op == OP_MULH)
         y = prod[2*LANE_W-1:LANE_W];
      else if (!sat_en)
         y = exact[LANE_W-1:0];
      else if ($signed(exact) > $signed(hi_lim))
         y = hi_lim[LANE_W-1:0];
      else if ($signed(exact) < $signed(lo_lim))
         y = lo_lim[LANE_W-1:0];
      else
         y = exact[LANE_W-1:0];
   end

endmodule

// File: rtl/simd_lane_array.sv
module simd_lane_array
   import simd_pkg::*;
#(
   parameter int VEC_W  = 128,
   parameter int LANE_W = 8
)(
   input  logic [VEC_W-1:0] a,
   input  logic [VEC_W-1:0] b,
   input  logic [VEC_W-1:0] c,
   input  op_e              op,
   input  logic             signed_mode,
   input  logic             sat_en,
   output logic [VEC_W-1:0] y
);

   localparam int N_LANES = VEC_W / LANE_W;

   if (VEC_W % LANE_W != 0) begin : g_bad_div
      $error("simd_lane_array: VEC_W must be a multiple of LANE_W");
   end

   for (genvar j = 0; j < N_LANES; j++) begin : g_lane
      simd_lane_unit #(.LANE_W(LANE_W)) u_lane (
         .a           (a[j*LANE_W +: LANE_W]),
         .b           (b[j*LANE_W +: LANE_W]),
         .c           (c[j*LANE_W +: LANE_W]),
         .op          (op),
         .signed_mode (signed_mode),
         .sat_en      (sat_en),
         .y           (y[j*LANE_W +: LANE_W])
      );
   end

endmodule

// File: rtl/simd_int_alu.sv
module simd_int_alu
   import simd_pkg::*;
#(
   parameter int VEC_W    = 128,
   parameter int NARROW_W = 64
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [CTRL_W-1:0]    ctrl,
   input  logic [VEC_W-1:0]     src_a,
   input  logic [VEC_W-1:0]     src_b,
   input  logic [VEC_W-1:0]     src_acc,
   input  logic [VEC_W/8-1:0]   lane_mask,
   output logic                 res_valid,
   output logic                 res_illegal,
   output logic [VEC_W-1:0]     result
);

   localparam int N_BYTES    = VEC_W / 8;
   localparam int NARROW_BYT = NARROW_W / 8;
   localparam int MAX_LANE_W = 8 << (NUM_ELEM_W - 1);

   if (NARROW_W % MAX_LANE_W != 0 || VEC_W != 2 * NARROW_W) begin : g_bad_cfg
      $error("simd_int_alu: VEC_W must be twice NARROW_W, a multiple of the widest lane");
   end

   dec_t dec;

   simd_ctrl_decode u_dec (
      .ctrl (ctrl),
      .dec  (dec)
   );

   logic [VEC_W-1:0] lane_res [NUM_ELEM_W];

   for (genvar k = 0; k < NUM_ELEM_W; k++) begin : g_elem
      simd_lane_array #(.VEC_W(VEC_W), .LANE_W(8 << k)) u_arr (
         .a           (src_a),
         .b           (src_b),
         .c           (src_acc),
         .op          (dec.op),
         .signed_mode (dec.signed_mode),
         .sat_en      (dec.sat_en),
         .y           (lane_res[k])
      );
   end

   logic [VEC_W-1:0]   sel_res;
   logic [VEC_W-1:0]   merged;
   logic [N_BYTES-1:0] byte_en;

   always_comb begin
      sel_res = lane_res[dec.elem_sel];
      for (int bi = 0; bi < N_BYTES; bi++) begin
         byte_en[bi] = lane_mask[bi >> dec.elem_sel];
         if (dec.narrow && bi >= NARROW_BYT)
            merged[bi*8 +: 8] = 8'h00;
         else if (byte_en[bi])
            merged[bi*8 +: 8] = sel_res[bi*8 +: 8];
         else
            merged[bi*8 +: 8] = src_a[bi*8 +: 8];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid   <= 1'b0;
         res_illegal <= 1'b0;
         result      <= '0;
      end else begin
         res_valid   <= in_valid;
         res_illegal <= in_valid && dec.illegal;
         if (in_valid)
            result <= dec.illegal ? '0 : merged;
      end
   end

endmodule

// File: rtl/simd_int_alu_chk.sv
module simd_int_alu_chk #(
   parameter int VEC_W = 128
)(
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [11:0]        ctrl,
   input logic [VEC_W-1:0]   src_a,
   input logic [VEC_W/8-1:0] lane_mask,
   input logic               res_valid,
   input logic               res_illegal,
   input logic [VEC_W-1:0]   result
);

   localparam int HALF = VEC_W / 2;

   logic legal;
   assign legal = !ctrl[1] && (ctrl[5:4] != 2'd1) && (ctrl[11:6] <= 6'd4);

   // R1
   lat_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> res_valid);

   // R1
   idle_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !res_valid && !res_illegal);

   // R2
   rsv_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && ctrl[1] |=> res_illegal && result == '0);

   // R4
   flt_cat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && ctrl[5:4] == 2'd1 |=> res_illegal && result == '0);

   // R5
   bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && ctrl[11:6] > 6'd4 |=> res_illegal);

   // R12
   narrow_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && legal && ctrl[1:0] == 2'd0 |=> result[VEC_W-1:HALF] == '0);

   // R11
   lane_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && legal && ctrl[1:0] == 2'd1 && lane_mask == '0
      |=> result == $past(src_a) && !res_illegal);

endmodule

bind simd_int_alu simd_int_alu_chk #(.VEC_W(VEC_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .ctrl        (ctrl),
   .src_a       (src_a),
   .lane_mask   (lane_mask),
   .res_valid   (res_valid),
   .res_illegal (res_illegal),
   .result      (result)
);

// File: tb/sim_simd_int_alu.sv
module sim_simd_int_alu;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         in_valid;
   logic [11:0]  ctrl;
   logic [127:0] src_a, src_b, src_acc;
   logic [15:0]  lane_mask;
   logic         res_valid, res_illegal;
   logic [127:0] result;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   simd_int_alu u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .ctrl        (ctrl),
      .src_a       (src_a),
      .src_b       (src_b),
      .src_acc     (src_acc),
      .lane_mask   (lane_mask),
      .res_valid   (res_valid),
      .res_illegal (res_illegal),
      .result      (result)
   );

   typedef struct packed {
      logic [11:0]  ctrl;
      logic [127:0] a;
      logic [127:0] b;
      logic [127:0] c;
      logic [15:0]  mask;
      logic [127:0] exp;
      logic         ill;
      logic [3:0]   req;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t TBL [NV] = '{
      // R6 wrap add, 8-bit lanes
      '{12'h001, {16{8'hF0}}, {16{8'h20}}, 128'h0, 16'hFFFF, {16{8'h10}}, 1'b0, 4'd6},
      // R3 wrap sub, 16-bit lanes
      '{12'h045, {8{16'h0001}}, {8{16'h0003}}, 128'h0, 16'hFFFF, {8{16'hFFFE}}, 1'b0, 4'd3},
      // R7 signed add overflows high
      '{12'h021, {16{8'h70}}, {16{8'h20}}, 128'h0, 16'hFFFF, {16{8'h7F}}, 1'b0, 4'd7},
      // R7 signed sub underflows, 32-bit lanes
      '{12'h069, {4{32'h80000000}}, {4{32'h1}}, 128'h0, 16'hFFFF, {4{32'h80000000}}, 1'b0, 4'd7},
      // R8 unsigned sub underflows to zero
      '{12'h071, {16{8'h10}}, {16{8'h20}}, 128'h0, 16'hFFFF, 128'h0, 1'b0, 4'd8},
      // R8 unsigned add overflows to all ones, 16-bit lanes
      '{12'h035, {8{16'hFFF0}}, {8{16'h0020}}, 128'h0, 16'hFFFF, {8{16'hFFFF}}, 1'b0, 4'd8},
      // R6 wrap mul low half, 32-bit lanes
      '{12'h089, {4{32'h00010003}}, {4{32'h00010002}}, 128'h0, 16'hFFFF, {4{32'h00050006}}, 1'b0, 4'd6},
      // R9 mulhi unsigned in wrap category
      '{12'h101, {16{8'hFF}}, {16{8'hFF}}, 128'h0, 16'hFFFF, {16{8'hFE}}, 1'b0, 4'd9},
      // R9 mulhi signed in signed-saturating category
      '{12'h121, {16{8'hFF}}, {16{8'h02}}, 128'h0, 16'hFFFF, {16{8'hFF}}, 1'b0, 4'd9},
      // R9 same operands unsigned saturating: unsigned high half
      '{12'h131, {16{8'hFF}}, {16{8'h02}}, 128'h0, 16'hFFFF, {16{8'h01}}, 1'b0, 4'd9},
      // R10 wrap mac, 16-bit lanes
      '{12'h0C5, {8{16'h0003}}, {8{16'h0004}}, {8{16'h0100}}, 16'hFFFF, {8{16'h010C}}, 1'b0, 4'd10},
      // R10 signed saturating mac clamps
      '{12'h0E1, {16{8'h02}}, {16{8'h03}}, {16{8'h7F}}, 16'hFFFF, {16{8'h7F}}, 1'b0, 4'd10},
      // R3 64-bit lanes, carry stays in lane
      '{12'h00D, {64'hFFFFFFFFFFFFFFFF, 64'h1}, {64'h1, 64'h1}, 128'h0, 16'hFFFF,
        {64'h0, 64'h2}, 1'b0, 4'd3},
      // R11 upper byte lanes masked off
      '{12'h001, {16{8'h11}}, {16{8'h01}}, 128'h0, 16'h00FF,
        {{8{8'h11}}, {8{8'h12}}}, 1'b0, 4'd11},
      // R11 32-bit lanes, holes and stray high mask bits
      '{12'h009, {4{32'h10}}, {4{32'h1}}, 128'h0, 16'hFFF5,
        {32'h10, 32'h11, 32'h10, 32'h11}, 1'b0, 4'd11},
      // R12 narrow width clears upper half
      '{12'h000, {16{8'h05}}, {16{8'h01}}, 128'h0, 16'hFFFF, {64'h0, {8{8'h06}}}, 1'b0, 4'd12},
      // R12 narrow width ignores mask bits above lane 7
      '{12'h000, {16{8'h05}}, {16{8'h01}}, 128'h0, 16'hFF00, {64'h0, {8{8'h05}}}, 1'b0, 4'd12},
      // R2 reserved width code
      '{12'h002, {16{8'h05}}, {16{8'h01}}, 128'h0, 16'hFFFF, 128'h0, 1'b1, 4'd2},
      // R4 floating-point category
      '{12'h011, {16{8'h05}}, {16{8'h01}}, 128'h0, 16'hFFFF, 128'h0, 1'b1, 4'd4},
      // R5 unknown operator code 5
      '{12'h141, {16{8'h05}}, {16{8'h01}}, 128'h0, 16'hFFFF, 128'h0, 1'b1, 4'd5}
   };

   task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      in_valid  = 1'b1;
      ctrl      = v.ctrl;
      src_a     = v.a;
      src_b     = v.b;
      src_acc   = v.c;
      lane_mask = v.mask;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n     = 1'b0;
      in_valid  = 1'b1;
      ctrl      = 12'h001;
      src_a     = {16{8'hAA}};
      src_b     = {16{8'h11}};
      src_acc   = '0;
      lane_mask = 16'hFFFF;
      repeat (3) @(negedge clk);
      // R1 reset state dominates a valid strobe
      check("R1 reset res_valid", {127'h0, res_valid}, 128'h0);
      check("R1 reset res_illegal", {127'h0, res_illegal}, 128'h0);
      check("R1 reset result", result, 128'h0);
      rst_n    = 1'b1;
      in_valid = 1'b0;
      @(negedge clk);
      // R1 no strobe, no result strobe
      check("R1 idle res_valid", {127'h0, res_valid}, 128'h0);

      drive(TBL[0]);
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         check($sformatf("R%0d vec%0d result", TBL[i].req, i), result, TBL[i].exp);
         check($sformatf("R%0d vec%0d illegal", TBL[i].req, i),
               {127'h0, res_illegal}, {127'h0, TBL[i].ill});
         check($sformatf("R1 vec%0d res_valid", i), {127'h0, res_valid}, 128'h1);
         if (i + 1 < NV) drive(TBL[i + 1]);
         else in_valid = 1'b0;
      end

      // R1 strobe drops one cycle after in_valid drops; result holds
      @(negedge clk);
      check("R1 drop res_valid", {127'h0, res_valid}, 128'h0);
      check("R1 drop res_illegal", {127'h0, res_illegal}, 128'h0);

      // R11 wide width, all lanes masked: result equals src_a
      drive('{12'h0C9, {32'h01234567, 32'h89ABCDEF, 32'hDEADBEEF, 32'h00C0FFEE},
              {4{32'h3}}, {4{32'h7}}, 16'h0000, 128'h0, 1'b0, 4'd11});
      @(negedge clk);
      in_valid = 1'b0;
      check("R11 all lanes off",
            result, {32'h01234567, 32'h89ABCDEF, 32'hDEADBEEF, 32'h00C0FFEE});

      // R7 signed saturating mul, 16-bit lanes
      drive('{12'h0A5, {8{16'h0100}}, {8{16'h0100}}, 128'h0, 16'hFFFF, 128'h0, 1'b0, 4'd7});
      @(negedge clk);
      in_valid = 1'b0;
      check("R7 signed mul clamp", result, {8{16'h7FFF}});

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule